// File: doc/BRIEF.md
# Barrel Shift and Rotate Unit

This block takes one operand per transfer and shifts or rotates it in a single combinational pass. Eight operations are supported: arithmetic, logical, plain rotate and rotate through a separate extend bit, each to the left or to the right. The operand is 8, 16 or 32 bits wide. The count comes from a 3-bit immediate field or from the low six bits of a register value. A single-step form, used for operands held in memory, shifts a 16-bit value by exactly one. The unit returns the shifted value together with the five condition flags: extend, negative, zero, overflow and carry.

Operands enter on a valid/ready port and results leave on a valid/ready port. A single output register separates the two ports. `in_ready` is high when that register is empty or when the consumer is taking its contents in the same cycle. A transfer takes place on a rising edge where `in_valid` and `in_ready` are both high. While `out_valid` is high and `out_ready` is low, the result and flags hold still and no new operand is accepted. Fetching the operand is the job of the surrounding datapath.

Top module: `shrot_unit`

## Requirements
- R1: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. An accepted operand appears on `out_valid`/`out_data` one cycle later. While `out_valid` is high and `out_ready` is low, the result and flags stay unchanged.
- R2: With `in_cnt_sel`=0 the count is `in_cnt_imm`, where codes 1 to 7 mean that many positions and code 0 means 8. With `in_cnt_sel`=1 the count is `in_cnt_reg` modulo 64.
- R3: `in_size` selects the operand width: 00 byte, 01 word, 10 or 11 long. Only the low 8, 16 or 32 bits are processed. Bits of `out_data` above the operand width pass through unchanged from `in_data`.
- R4: With `in_mem`=1 the count is 1 and the size is word, whatever the size and count inputs are.
- R5: Logical shifts (`in_op` 010 left, 011 right) fill vacated bits with zero. C and X take the last bit shifted out, and V is 0. A count larger than the width gives a zero result and C=0.
- R6: Arithmetic right shift (`in_op` 001) fills vacated bits with the sign bit, and C and X take the last bit shifted out. A count of at least the width gives all sign bits, with C equal to the sign.
- R7: Arithmetic left shift (`in_op` 000) gives the same value and C/X as a logical left shift. V is 1 exactly when the most significant bit changed at any step of the shift.
- R8: Plain rotates (`in_op` 100 left, 101 right) rotate by the count modulo the width. C is the last bit carried round: bit 0 of the result for left and the top bit for right. X is unchanged and V is 0.
- R9: Rotates through extend (`in_op` 110 left, 111 right) rotate a ring made of X above the operand, by the count modulo width+1. Both X and C take the new extend bit, and V is 0.
- R10: A count of zero leaves the value unchanged and clears V. X is unchanged. C is cleared, except for rotates through extend, where C takes X.
- R11: N equals the top bit of the result at the operand width. Z is 1 exactly when the result at the operand width is zero.
- R12: During reset `out_valid`, `out_data` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken |
| in_op | input | 3 | Operation code |
| in_size | input | 2 | Operand width code |
| in_cnt_sel | input | 1 | 0 immediate count, 1 register count |
| in_cnt_imm | input | 3 | Immediate count, 0 means 8 |
| in_cnt_reg | input | REG_CNT_W | Register count, taken modulo 64 |
| in_mem | input | 1 | Single-step word form |
| in_data | input | DATA_W | Operand |
| in_x | input | 1 | Current extend flag |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes result |
| out_data | output | DATA_W | Shifted value |
| out_x | output | 1 | Extend flag |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag |
| out_c | output | 1 | Carry flag |

## Verification
The hardest states to reach from the ports are the edges of the count arithmetic. These are a register value whose low six bits are zero, a register count larger than the width, and a rotate through extend whose count is an exact multiple of width+1. In each of these the carry must come from the extend bit or from the sign, not from a shifted data bit. The vector table reaches them with chosen register values (64, 40, 33, 65, 32), and each vector sets the extend input opposite to the data bits. A directed test holds `out_ready` low while a second operand waits, and then releases both in the same cycle.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [2:0] {
    OP_ASL = 3'd0,
    OP_ASR = 3'd1,
    OP_LSL = 3'd2,
    OP_LSR = 3'd3,
    OP_ROL = 3'd4,
    OP_ROR = 3'd5,
    OP_RXL = 3'd6,
    OP_RXR = 3'd7
  } shrot_op_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } shrot_flags_t;

  localparam int NUM_LANES = 3;

endpackage

// File: rtl/shrot_count.sv
module shrot_count #(
  parameter int REG_CNT_W = 8,
  parameter int CNT_W     = 6,
  parameter int IMM_W     = 3
) (
  input  logic                 sel_reg_i,
  input  logic [IMM_W-1:0]     imm_i,
  input  logic [REG_CNT_W-1:0] reg_i,
  input  logic                 mem_i,
  input  logic [1:0]           size_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic [1:0]           lane_o
);
  localparam int IMM_ZERO_MEANS = 1 << IMM_W;

  always_comb begin
    if (mem_i) begin
      cnt_o  = CNT_W'(1);
      lane_o = 2'd1;
    end else begin
      if (sel_reg_i)
        cnt_o = CNT_W'(reg_i);
      else if (imm_i == '0)
        cnt_o = CNT_W'(IMM_ZERO_MEANS);
      else
        cnt_o = CNT_W'(imm_i);
      case (size_i)
        2'd0:    lane_o = 2'd0;
        2'd1:    lane_o = 2'd1;
        default: lane_o = 2'd2;
      endcase
    end
  end
endmodule

// File: rtl/shrot_lane.sv
module shrot_lane
  import shrot_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 6
) (
  input  shrot_op_e        op_i,
  input  logic [W-1:0]     d_i,
  input  logic             x_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [W-1:0]     res_o,
  output shrot_flags_t     flg_o
);
  localparam int RING_W = W + 1;

  logic [W:0]    lsl_w, lsr_w, asr_w;
  logic [W-1:0]  probe;
  logic          asl_v;
  logic [31:0]   amt, rr, rx;
  logic [W-1:0]  rol_w, ror_w;
  logic [W:0]    ring, rxl_w, rxr_w;
  logic          cnt_zero;

  always_comb begin
    cnt_zero = (cnt_i == '0);
    lsl_w = {1'b0, d_i} << cnt_i;
    lsr_w = {d_i, 1'b0} >> cnt_i;
    asr_w = $unsigned($signed({d_i, 1'b0}) >>> cnt_i);

    // overflow: top cnt+1 bits of the operand must all agree
    amt   = '0;
    probe = '0;
    if (32'(cnt_i) >= 32'(W)) begin
      asl_v = |d_i;
    end else begin
      amt   = 32'(W - 1) - 32'(cnt_i);
      probe = $unsigned($signed(d_i) >>> amt);
      asl_v = !((probe == '0) || (probe == '1));
    end

    rr    = 32'(cnt_i) % 32'(W);
    rol_w = (d_i << rr) | (d_i >> (32'(W) - rr));
    ror_w = (d_i >> rr) | (d_i << (32'(W) - rr));

    ring  = {x_i, d_i};
    rx    = 32'(cnt_i) % 32'(RING_W);
    rxl_w = (ring << rx) | (ring >> (32'(RING_W) - rx));
    rxr_w = (ring >> rx) | (ring << (32'(RING_W) - rx));
  end

  always_comb begin
    res_o   = d_i;
    flg_o   = '0;
    flg_o.x = x_i;
    unique case (op_i)
      OP_ASL: begin
        res_o   = lsl_w[W-1:0];
        flg_o.c = cnt_zero ? 1'b0 : lsl_w[W];
        flg_o.x = cnt_zero ? x_i  : lsl_w[W];
        flg_o.v = asl_v;
      end
      OP_LSL: begin
        res_o   = lsl_w[W-1:0];
        flg_o.c = cnt_zero ? 1'b0 : lsl_w[W];
        flg_o.x = cnt_zero ? x_i  : lsl_w[W];
      end
      OP_LSR: begin
        res_o   = lsr_w[W:1];
        flg_o.c = cnt_zero ? 1'b0 : lsr_w[0];
        flg_o.x = cnt_zero ? x_i  : lsr_w[0];
      end
      OP_ASR: begin
        res_o   = asr_w[W:1];
        flg_o.c = cnt_zero ? 1'b0 : asr_w[0];
        flg_o.x = cnt_zero ? x_i  : asr_w[0];
      end
      OP_ROL: begin
        res_o   = rol_w;
        flg_o.c = cnt_zero ? 1'b0 : rol_w[0];
      end
      OP_ROR: begin
        res_o   = ror_w;
        flg_o.c = cnt_zero ? 1'b0 : ror_w[W-1];
      end
      OP_RXL: begin
        res_o   = rxl_w[W-1:0];
        flg_o.c = rxl_w[W];
        flg_o.x = rxl_w[W];
      end
      OP_RXR: begin
        res_o   = rxr_w[W-1:0];
        flg_o.c = rxr_w[W];
        flg_o.x = rxr_w[W];
      end
      default: ;
    endcase
    flg_o.n = res_o[W-1];
    flg_o.z = (res_o == '0);
  end
endmodule

// File: rtl/shrot_outreg.sv
module shrot_outreg
  import shrot_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [DW-1:0] d_i,
  input  shrot_flags_t f_i,
  input  logic         take_i,
  output logic         valid_o,
  output logic [DW-1:0] q_o,
  output shrot_flags_t f_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      q_o     <= '0;
      f_o     <= '0;
    end else begin
      if (load_i) begin
        valid_o <= 1'b1;
        q_o     <= d_i;
        f_o     <= f_i;
      end else if (take_i) begin
        valid_o <= 1'b0;
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !take_i) |=> (valid_o && $stable(q_o) && $stable(f_o))); // R1
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_CNT_W = 8,
  parameter int CNT_W     = 6,
  parameter int IMM_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [2:0]           in_op,
  input  logic [1:0]           in_size,
  input  logic                 in_cnt_sel,
  input  logic [IMM_W-1:0]     in_cnt_imm,
  input  logic [REG_CNT_W-1:0] in_cnt_reg,
  input  logic                 in_mem,
  input  logic [DATA_W-1:0]    in_data,
  input  logic                 in_x,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DATA_W-1:0]    out_data,
  output logic                 out_x,
  output logic                 out_n,
  output logic                 out_z,
  output logic                 out_v,
  output logic                 out_c
);
  shrot_op_e    op;
  logic [CNT_W-1:0] cnt;
  logic [1:0]   lane_sel;
  logic         accept;
  logic [DATA_W-1:0] lane_res  [NUM_LANES];
  logic [DATA_W-1:0] lane_mask [NUM_LANES];
  shrot_flags_t lane_flg [NUM_LANES];
  logic [DATA_W-1:0] merged;
  shrot_flags_t sel_flg, q_flg;

  assign op       = shrot_op_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  shrot_count #(.REG_CNT_W(REG_CNT_W), .CNT_W(CNT_W), .IMM_W(IMM_W)) u_count (
    .sel_reg_i(in_cnt_sel),
    .imm_i    (in_cnt_imm),
    .reg_i    (in_cnt_reg),
    .mem_i    (in_mem),
    .size_i   (in_size),
    .cnt_o    (cnt),
    .lane_o   (lane_sel)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? 8 : ((g == 1) ? 16 : DATA_W);
    logic [LW-1:0] r;
    shrot_lane #(.W(LW), .CNT_W(CNT_W)) u_lane (
      .op_i (op),
      .d_i  (in_data[LW-1:0]),
      .x_i  (in_x),
      .cnt_i(cnt),
      .res_o(r),
      .flg_o(lane_flg[g])
    );
    assign lane_res[g]  = DATA_W'(r);
    assign lane_mask[g] = DATA_W'({LW{1'b1}});
  end

  always_comb begin
    case (lane_sel)
      2'd0: begin
        merged  = (in_data & ~lane_mask[0]) | lane_res[0];
        sel_flg = lane_flg[0];
      end
      2'd1: begin
        merged  = (in_data & ~lane_mask[1]) | lane_res[1];
        sel_flg = lane_flg[1];
      end
      default: begin
        merged  = (in_data & ~lane_mask[2]) | lane_res[2];
        sel_flg = lane_flg[2];
      end
    endcase
  end

  shrot_outreg #(.DW(DATA_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .d_i    (merged),
    .f_i    (sel_flg),
    .take_i (out_ready),
    .valid_o(out_valid),
    .q_o    (out_data),
    .f_o    (q_flg)
  );

  assign out_x = q_flg.x;
  assign out_n = q_flg.n;
  assign out_z = q_flg.z;
  assign out_v = q_flg.v;
  assign out_c = q_flg.c;

  AST_IMM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_cnt_sel && !in_mem) |-> (cnt != '0)); // R2
  AST_ZERO_CNT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cnt == '0 && op != OP_RXL && op != OP_RXR) |=> !out_c); // R10
  AST_X_FOLLOWS_C: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cnt != '0 && op != OP_ROL && op != OP_ROR) |=> (out_x == out_c)); // R5
  AST_V_ONLY_ASL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op != OP_ASL) |=> !out_v); // R7
  AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid); // R1
endmodule

// File: tb/tb_shrot_unit.sv
`timescale 1ns/1ps
module tb_shrot_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic        in_cnt_sel = 1'b0;
  logic [2:0]  in_cnt_imm = '0;
  logic [7:0]  in_cnt_reg = '0;
  logic        in_mem = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_x = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_x, out_n, out_z, out_v, out_c;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  shrot_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_size(in_size), .in_cnt_sel(in_cnt_sel),
    .in_cnt_imm(in_cnt_imm), .in_cnt_reg(in_cnt_reg), .in_mem(in_mem),
    .in_data(in_data), .in_x(in_x), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_x(out_x),
    .out_n(out_n), .out_z(out_z), .out_v(out_v), .out_c(out_c)
  );

  // {op, size, sel, imm, reg, mem, x, data, expected data, expected {x,n,z,v,c}}
  localparam int NV = 18;
  localparam logic [87:0] VEC [NV] = '{
    {3'd2,2'd0,1'b0,3'd3,8'd0, 1'b0,1'b0,32'hAABBCC81,32'hAABBCC08,5'b00000},
    {3'd3,2'd1,1'b1,3'd0,8'd4, 1'b0,1'b1,32'h12348F0F,32'h123408F0,5'b10001},
    {3'd1,2'd0,1'b0,3'd2,8'd0, 1'b0,1'b0,32'h00000085,32'h000000E1,5'b01000},
    {3'd1,2'd2,1'b1,3'd0,8'd40,1'b0,1'b0,32'h80000000,32'hFFFFFFFF,5'b11001},
    {3'd0,2'd0,1'b0,3'd1,8'd0, 1'b0,1'b0,32'h00000040,32'h00000080,5'b01010},
    {3'd0,2'd1,1'b0,3'd0,8'd0, 1'b0,1'b0,32'h0000FF80,32'h00008000,5'b11001},
    {3'd2,2'd2,1'b1,3'd0,8'h41,1'b0,1'b0,32'h80000001,32'h00000002,5'b10001},
    {3'd4,2'd0,1'b0,3'd3,8'd0, 1'b0,1'b1,32'h000000B1,32'h0000008D,5'b11001},
    {3'd5,2'd1,1'b1,3'd0,8'd20,1'b0,1'b0,32'h00001234,32'h00004123,5'b00000},
    {3'd6,2'd0,1'b0,3'd1,8'd0, 1'b0,1'b1,32'h00000080,32'h00000001,5'b10001},
    {3'd7,2'd2,1'b1,3'd0,8'd33,1'b0,1'b1,32'h12345678,32'h12345678,5'b10001},
    {3'd3,2'd1,1'b1,3'd0,8'd0, 1'b0,1'b1,32'h00008000,32'h00008000,5'b11000},
    {3'd6,2'd0,1'b1,3'd0,8'd64,1'b0,1'b1,32'h00000000,32'h00000000,5'b10101},
    {3'd1,2'd2,1'b0,3'd5,8'd0, 1'b1,1'b0,32'hFFFF8003,32'hFFFFC001,5'b11001},
    {3'd3,2'd0,1'b0,3'd0,8'd0, 1'b0,1'b0,32'h12345680,32'h12345600,5'b10101},
    {3'd2,2'd3,1'b0,3'd1,8'd0, 1'b0,1'b0,32'h40000000,32'h80000000,5'b01000},
    {3'd0,2'd2,1'b1,3'd0,8'd32,1'b0,1'b0,32'h00000001,32'h00000000,5'b10111},
    {3'd4,2'd1,1'b1,3'd0,8'd16,1'b0,1'b0,32'h00008001,32'h00008001,5'b01001}
  };
  localparam string VREQ [NV] = '{
    "R5", "R5", "R6", "R6", "R7", "R2", "R2", "R8", "R8",
    "R9", "R9", "R10", "R10", "R4", "R11", "R3", "R7", "R8"
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [36:0] act, input logic [36:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [87:0] v);
    in_op      = v[87:85];
    in_size    = v[84:83];
    in_cnt_sel = v[82];
    in_cnt_imm = v[81:79];
    in_cnt_reg = v[78:71];
    in_mem     = v[70];
    in_x       = v[69];
    in_data    = v[68:37];
  endtask

  function automatic logic [36:0] observed();
    return {out_data, out_x, out_n, out_z, out_v, out_c};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset state, R12
    repeat (3) @(negedge clk);
    check(observed() == '0 && !out_valid, "R12", "reset outputs",
          {out_valid, observed()[35:0]}, '0);
    check(in_ready == 1'b1, "R1", "ready when empty", {36'd0, in_ready}, 37'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid && observed() == VEC[i][36:0], VREQ[i],
            $sformatf("vector %0d", i), observed(), VEC[i][36:0]);
    end
    @(negedge clk);
    check(!out_valid, "R1", "drain after take", {36'd0, out_valid}, 37'd0);

    // back-pressure, R1
    out_ready = 1'b0;
    drive(VEC[0]);
    in_valid = 1'b1;
    @(negedge clk);
    drive(VEC[7]);
    check(!in_ready, "R1", "ready low while stalled", {36'd0, in_ready}, 37'd0);
    @(negedge clk);
    check(out_valid && observed() == VEC[0][36:0], "R1", "hold while stalled",
          observed(), VEC[0][36:0]);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && observed() == VEC[7][36:0], "R1", "next after release",
          observed(), VEC[7][36:0]);

    // mem form ignores size and count fields, R4
    drive(VEC[13]);
    in_size    = 2'd0;
    in_cnt_sel = 1'b1;
    in_cnt_reg = 8'd9;
    in_valid   = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(observed() == VEC[13][36:0], "R4", "mem form fixed count",
          observed(), VEC[13][36:0]);

    // plain rotate keeps X with count zero, R10
    drive(VEC[7]);
    in_cnt_sel = 1'b1;
    in_cnt_reg = 8'd128;
    in_valid   = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(observed() == {32'h000000B1, 5'b11000}, "R10", "rotate count zero",
          observed(), {32'h000000B1, 5'b11000});

    // reset mid-stream clears held result, R12
    out_ready = 1'b0;
    drive(VEC[1]);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(!out_valid && observed() == '0, "R12", "reset clears result",
          observed(), '0);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule